// File: doc/BRIEF.md
# Saturating Add/Subtract Unit

This unit performs 32-bit signed arithmetic that clamps instead of wrapping. It supports three operations: add, subtract, and reverse subtract. The destination-side operand always comes from a register value. The other operand is chosen from three sources: a second register value, a sign-extended 5-bit immediate, or a sign-extended 16-bit immediate. The unit registers the clamped result together with five status bits: carry, overflow, sign, zero and a sticky saturation indicator.

An operation is presented for one cycle with `op_valid` high. Its result and flags appear at the outputs after the next rising clock edge, and `res_valid` marks that cycle. The surrounding pipeline decides which architectural register receives the result. The three-operand immediate subtract therefore needs nothing special here: the source register value goes in on `dst_val`, and the caller writes the result wherever it chooses. The saturation flag stays set once any operation has clamped. It is cleared only through `sat_clr`.

Top module: `satarith_unit`

## Requirements
- R1: Operation codes on `op_sel`: 0 gives `dst_val + S`, 1 gives `dst_val - S`, 2 gives `S - dst_val`, where S is the selected second operand.
- R2: Source codes on `src_sel`: 0 selects `src_val`, 1 selects `imm_short` sign-extended from bit 4, 2 selects `imm_long` sign-extended from bit 15. The unselected inputs have no effect.
- R3: When the exact signed result exceeds the 32-bit range upward, `result` is 0x7FFFFFFF. When it falls below the range, `result` is 0x80000000. Otherwise `result` is the exact value.
- R4: `flag_ov` is 1 exactly when the exact signed result of the operation does not fit in 32 bits.
- R5: For an add, `flag_cy` is the unsigned carry out of bit 31. For both subtract forms, `flag_cy` is the unsigned borrow, which is 1 when the minuend is below the subtrahend as unsigned numbers.
- R6: `flag_s` equals bit 31 of the clamped `result`. `flag_z` is 1 exactly when the clamped `result` is zero.
- R7: `flag_sat` becomes 1 after any operation that clamps. It stays 1 through later operations that do not clamp. It returns to 0 on a cycle where `sat_clr` is high and no clamping operation is presented. A clamping operation in the same cycle as `sat_clr` leaves it at 1.
- R8: When `op_valid` is low, `result`, `flag_cy`, `flag_ov`, `flag_s` and `flag_z` keep their values.
- R9: `res_valid` is high in exactly the cycle after a cycle with `op_valid` high, so each result appears one edge after it is presented.
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation presented this cycle |
| op_sel | input | 2 | Operation code (R1) |
| src_sel | input | 2 | Second-operand source code (R2) |
| dst_val | input | 32 | Destination-side register value |
| src_val | input | 32 | Source register value |
| imm_short | input | 5 | Short immediate field |
| imm_long | input | 16 | Long immediate field |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| result | output | 32 | Clamped result |
| res_valid | output | 1 | Result and flags updated at the last edge |
| flag_cy | output | 1 | Carry or borrow |
| flag_ov | output | 1 | Signed overflow |
| flag_s | output | 1 | Sign of the result |
| flag_z | output | 1 | Result is zero |
| flag_sat | output | 1 | Sticky saturation indicator |

## Verification
Every piece of state sits behind a single register stage, so a faulty internal value shows at the ports one edge after the operation that produced it. The most likely wrong state is a mismatch between the clamp and the overflow condition. That shows as a wrapped value beside `flag_ov`=1, or as a clamp constant beside `flag_ov`=0, on the very next `res_valid` cycle. A faulty sticky bit takes longer to see. It only becomes visible when a later non-clamping operation or an idle cycle should have kept `flag_sat` or cleared it, so the stimulus places non-clamping work and `sat_clr` pulses right after clamping operations.

// File: rtl/satarith_pkg.sv
package satarith_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_RSUB = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        SRC_REG   = 2'd0,
        SRC_SHORT = 2'd1,
        SRC_LONG  = 2'd2
    } src_e;

    typedef struct packed {
        logic cy;
        logic ov;
        logic s;
        logic z;
        logic sat;
    } flags_t;

endpackage

// File: rtl/satarith_opsel.sv
module satarith_opsel
    import satarith_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = 5,
    parameter int LW = 16
) (
    input  logic [1:0]    src_sel,
    input  logic [W-1:0]  reg_val,
    input  logic [SW-1:0] imm_s,
    input  logic [LW-1:0] imm_l,
    output logic [W-1:0]  operand
);
    localparam int SEXT_S = W - SW;
    localparam int SEXT_L = W - LW;

    logic [W-1:0] short_ext;
    logic [W-1:0] long_ext;

    assign short_ext = {{SEXT_S{imm_s[SW-1]}}, imm_s};
    assign long_ext  = {{SEXT_L{imm_l[LW-1]}}, imm_l};

    always_comb begin
        case (src_e'(src_sel))
            SRC_SHORT: operand = short_ext;
            SRC_LONG:  operand = long_ext;
            default:   operand = reg_val;
        endcase
    end
endmodule

// File: rtl/satarith_core.sv
module satarith_core
    import satarith_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]   op_sel,
    input  logic [W-1:0] dst,
    input  logic [W-1:0] src,
    output logic [W-1:0] clamped,
    output logic         carry,
    output logic         overflow
);
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] lhs;
    logic [W-1:0] rhs;
    logic         is_sub;
    logic [W:0]   wide_s;
    logic [W:0]   wide_u;

    // Pick minuend/subtrahend ordering from the operation code
    always_comb begin
        case (op_e'(op_sel))
            OP_SUB: begin
                lhs    = dst;
                rhs    = src;
                is_sub = 1'b1;
            end
            OP_RSUB: begin
                lhs    = src;
                rhs    = dst;
                is_sub = 1'b1;
            end
            default: begin
                lhs    = dst;
                rhs    = src;
                is_sub = 1'b0;
            end
        endcase
    end

    // One extra bit holds the exact signed and unsigned outcomes
    always_comb begin
        if (is_sub) begin
            wide_s = {lhs[W-1], lhs} - {rhs[W-1], rhs};
            wide_u = {1'b0, lhs} - {1'b0, rhs};
        end else begin
            wide_s = {lhs[W-1], lhs} + {rhs[W-1], rhs};
            wide_u = {1'b0, lhs} + {1'b0, rhs};
        end
    end

    assign overflow = wide_s[W] ^ wide_s[W-1];
    assign carry    = wide_u[W];

    always_comb begin
        if (!overflow)
            clamped = wide_s[W-1:0];
        else if (wide_s[W])
            clamped = MAX_NEG;
        else
            clamped = MAX_POS;
    end
endmodule

// File: rtl/satarith_unit.sv
module satarith_unit
    import satarith_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = 5,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [1:0]    op_sel,
    input  logic [1:0]    src_sel,
    input  logic [W-1:0]  dst_val,
    input  logic [W-1:0]  src_val,
    input  logic [SW-1:0] imm_short,
    input  logic [LW-1:0] imm_long,
    input  logic          sat_clr,
    output logic [W-1:0]  result,
    output logic          res_valid,
    output logic          flag_cy,
    output logic          flag_ov,
    output logic          flag_s,
    output logic          flag_z,
    output logic          flag_sat
);
    typedef struct packed {
        logic [W-1:0] res;
        flags_t       flg;
        logic         vld;
    } state_t;

    state_t       st_d;
    state_t       st_q;
    logic [W-1:0] operand;
    logic [W-1:0] core_res;
    logic         core_cy;
    logic         core_ov;

    satarith_opsel #(.W(W), .SW(SW), .LW(LW)) u_opsel (
        .src_sel (src_sel),
        .reg_val (src_val),
        .imm_s   (imm_short),
        .imm_l   (imm_long),
        .operand (operand)
    );

    satarith_core #(.W(W)) u_core (
        .op_sel   (op_sel),
        .dst      (dst_val),
        .src      (operand),
        .clamped  (core_res),
        .carry    (core_cy),
        .overflow (core_ov)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = op_valid;
        if (op_valid) begin
            st_d.res    = core_res;
            st_d.flg.cy = core_cy;
            st_d.flg.ov = core_ov;
            st_d.flg.s  = core_res[W-1];
            st_d.flg.z  = (core_res == '0);
        end
        // A clamp this cycle wins over a clear request
        if (op_valid && core_ov)
            st_d.flg.sat = 1'b1;
        else if (sat_clr)
            st_d.flg.sat = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign result    = st_q.res;
    assign res_valid = st_q.vld;
    assign flag_cy   = st_q.flg.cy;
    assign flag_ov   = st_q.flg.ov;
    assign flag_s    = st_q.flg.s;
    assign flag_z    = st_q.flg.z;
    assign flag_sat  = st_q.flg.sat;
endmodule

// File: rtl/satarith_checker.sv
module satarith_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic         sat_clr,
    input logic [W-1:0] result,
    input logic         res_valid,
    input logic         flag_ov,
    input logic         flag_s,
    input logic         flag_z,
    input logic         flag_sat
);
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

    a_r3_clamp_value: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && flag_ov) |-> (result == MAX_POS || result == MAX_NEG));

    a_r6_sign_matches: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (flag_s == result[W-1]));

    a_r6_zero_matches: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (flag_z == (result == '0)));

    a_r7_sat_follows_ov: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && flag_ov) |-> flag_sat);

    a_r7_sat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_sat && !sat_clr) |=> flag_sat);

    a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(result));

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    a_r9_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid);
endmodule

bind satarith_unit satarith_checker #(.W(W)) u_satarith_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .sat_clr   (sat_clr),
    .result    (result),
    .res_valid (res_valid),
    .flag_ov   (flag_ov),
    .flag_s    (flag_s),
    .flag_z    (flag_z),
    .flag_sat  (flag_sat)
);

// File: tb/satarith_unit_bench.sv
`timescale 1ns/1ps
module satarith_unit_bench;

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  src;
        logic [31:0] a;
        logic [31:0] b;
        logic [4:0]  i5;
        logic [15:0] i16;
        logic [31:0] er;
        logic        ecy;
        logic        eov;
    } vec_t;

    localparam int NV = 16;
    // op: 0 add, 1 sub, 2 rsub (R1); src: 0 reg, 1 imm5, 2 imm16 (R2)
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 32'h00000005, 32'h00000007, 5'h00, 16'h0000, 32'h0000000C, 1'b0, 1'b0},
        '{2'd0, 2'd0, 32'h7FFFFFFF, 32'h00000001, 5'h00, 16'h0000, 32'h7FFFFFFF, 1'b0, 1'b1},
        '{2'd0, 2'd0, 32'h80000000, 32'hFFFFFFFF, 5'h00, 16'h0000, 32'h80000000, 1'b1, 1'b1},
        '{2'd0, 2'd0, 32'hFFFFFFFF, 32'h00000001, 5'h00, 16'h0000, 32'h00000000, 1'b1, 1'b0},
        '{2'd1, 2'd0, 32'h00000003, 32'h00000005, 5'h00, 16'h0000, 32'hFFFFFFFE, 1'b1, 1'b0},
        '{2'd1, 2'd0, 32'h80000000, 32'h00000001, 5'h00, 16'h0000, 32'h80000000, 1'b0, 1'b1},
        '{2'd1, 2'd0, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'h00, 16'h0000, 32'h7FFFFFFF, 1'b1, 1'b1},
        '{2'd2, 2'd0, 32'h0000000A, 32'h00000003, 5'h00, 16'h0000, 32'hFFFFFFF9, 1'b1, 1'b0},
        '{2'd2, 2'd0, 32'h00000001, 32'h80000000, 5'h00, 16'h0000, 32'h80000000, 1'b0, 1'b1},
        '{2'd0, 2'd1, 32'h00000064, 32'hDEADBEEF, 5'h10, 16'h1234, 32'h00000054, 1'b1, 1'b0},
        '{2'd0, 2'd1, 32'h7FFFFFF0, 32'hDEADBEEF, 5'h0F, 16'h1234, 32'h7FFFFFFF, 1'b0, 1'b0},
        '{2'd0, 2'd1, 32'h7FFFFFF1, 32'hDEADBEEF, 5'h0F, 16'h1234, 32'h7FFFFFFF, 1'b0, 1'b1},
        '{2'd1, 2'd2, 32'h00000000, 32'hDEADBEEF, 5'h1F, 16'h8000, 32'h00008000, 1'b1, 1'b0},
        '{2'd1, 2'd2, 32'h80000000, 32'hDEADBEEF, 5'h1F, 16'h0001, 32'h80000000, 1'b0, 1'b1},
        '{2'd2, 2'd1, 32'h00000005, 32'hDEADBEEF, 5'h03, 16'hFFFF, 32'hFFFFFFFE, 1'b1, 1'b0},
        '{2'd1, 2'd0, 32'h12345678, 32'h12345678, 5'h00, 16'h0000, 32'h00000000, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_sel = '0;
    logic [1:0]  src_sel = '0;
    logic [31:0] dst_val = '0;
    logic [31:0] src_val = '0;
    logic [4:0]  imm_short = '0;
    logic [15:0] imm_long = '0;
    logic        sat_clr = 1'b0;
    logic [31:0] result;
    logic        res_valid;
    logic        flag_cy, flag_ov, flag_s, flag_z, flag_sat;

    int checks = 0;
    int errors = 0;
    logic sat_exp = 1'b0;

    always #4 clk = ~clk;

    satarith_unit u_satarith_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .src_sel(src_sel), .dst_val(dst_val), .src_val(src_val),
        .imm_short(imm_short), .imm_long(imm_long), .sat_clr(sat_clr),
        .result(result), .res_valid(res_valid), .flag_cy(flag_cy),
        .flag_ov(flag_ov), .flag_s(flag_s), .flag_z(flag_z), .flag_sat(flag_sat)
    );

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Present one operation at a falling edge; outputs are read at the next falling edge
    task automatic run_op(input vec_t v, input logic clr);
        @(negedge clk);
        op_valid  = 1'b1;
        op_sel    = v.op;
        src_sel   = v.src;
        dst_val   = v.a;
        src_val   = v.b;
        imm_short = v.i5;
        imm_long  = v.i16;
        sat_clr   = clr;
        @(negedge clk);
        op_valid  = 1'b0;
        sat_clr   = 1'b0;
    endtask

    task automatic check_vec(input vec_t v, input int idx);
        string w;
        w = $sformatf("vec%0d", idx);
        chk(result == v.er, "R1/R2/R3", {w, " result"}, result, v.er);
        chk(flag_ov == v.eov, "R4", {w, " ov"}, 32'(flag_ov), 32'(v.eov));
        chk(flag_cy == v.ecy, "R5", {w, " cy"}, 32'(flag_cy), 32'(v.ecy));
        chk(flag_s == v.er[31], "R6", {w, " sign"}, 32'(flag_s), 32'(v.er[31]));
        chk(flag_z == (v.er == 0), "R6", {w, " zero"}, 32'(flag_z), 32'(v.er == 0));
        chk(flag_sat == sat_exp, "R7", {w, " sat"}, 32'(flag_sat), 32'(sat_exp));
        chk(res_valid == 1'b1, "R9", {w, " valid"}, 32'(res_valid), 32'd1);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        vec_t v;
        vec_t probe;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(result == 0 && res_valid == 0 && flag_cy == 0 && flag_ov == 0 &&
            flag_s == 0 && flag_z == 0 && flag_sat == 0, "R10", "reset outputs",
            {result[26:0], res_valid, flag_cy, flag_ov, flag_s, flag_sat}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            run_op(v, 1'b0);
            sat_exp = sat_exp | v.eov;
            check_vec(v, i);
        end

        // R8/R9: idle cycle with changed inputs keeps result and flags
        held = result;
        @(negedge clk);
        dst_val = 32'h0BADF00D; src_val = 32'h11111111; op_sel = 2'd1;
        @(negedge clk);
        chk(result == held, "R8", "idle hold result", result, held);
        chk(flag_z == 1'b1 && flag_cy == 1'b0, "R8", "idle hold flags",
            {30'd0, flag_z, flag_cy}, 32'd2);
        chk(res_valid == 1'b0, "R9", "idle valid low", 32'(res_valid), 32'd0);

        // R7: clear with no clamp
        @(negedge clk);
        sat_clr = 1'b1;
        @(negedge clk);
        sat_clr = 1'b0;
        sat_exp = 1'b0;
        chk(flag_sat == 1'b0, "R7", "clear", 32'(flag_sat), 32'd0);

        // R7: clamp together with clear keeps flag set
        probe = VECS[1];
        run_op(probe, 1'b1);
        sat_exp = 1'b1;
        chk(flag_sat == 1'b1, "R7", "clamp wins over clear", 32'(flag_sat), 32'd1);
        chk(result == 32'h7FFFFFFF, "R3", "clamp with clear", result, 32'h7FFFFFFF);

        // R7: non-clamping op keeps sticky flag
        probe = VECS[0];
        run_op(probe, 1'b0);
        check_vec(probe, 100);

        // R7: non-clamping op with clear clears it
        run_op(probe, 1'b1);
        sat_exp = 1'b0;
        check_vec(probe, 101);

        // R2: register operand ignored in immediate mode
        probe = VECS[9];
        probe.b = 32'h00000001;
        run_op(probe, 1'b0);
        check_vec(probe, 102);

        // R10: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(result == 0 && res_valid == 0 && flag_cy == 0 && flag_sat == 0,
            "R10", "second reset", {result[28:0], res_valid, flag_cy, flag_sat}, 32'd0);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule